// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one channel of a multi-channel event timer. It watches a shared free-running 64-bit main counter, delivered as an input, and produces a one-cycle fire strobe when the counter reaches the channel's armed target. The channel has a one-shot mode and a periodic mode. It also has an optional 32-bit mode, in which only the low half of the counter is compared.

Software reaches the channel through neighbouring logic. That logic presents two kinds of write strobe: a configuration word write, and a comparator half-word write with a half select. The channel returns the visible comparator and the configuration word for readback. In periodic mode a hidden period register advances the target after each match. A set-value bit lets software also place the first target directly. In 32-bit one-shot mode, a target that lies beyond the next 32-bit rollover of the counter produces an extra fire at the rollover point.

Interrupt routing, status bits and address decode belong to other blocks.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the visible comparator reads all ones, the configuration word reads 0x18 (bit 3 periodic-capable and bit 4 64-bit-capable set, all else zero), the hidden period is zero and fire_o is low.
- R2: In one-shot 64-bit mode (config bit 0 = 0, bit 1 = 0), fire_o is high for the single cycle in which count_i equals the comparator, and the channel then stays silent until it is re-armed.
- R3: fire_o stays low while glb_en_i is 0. Two cycles after glb_en_i rises, the channel is re-armed from the current comparator and count.
- R4: In 32-bit mode (config bit 1 = 1) only the low 32 bits of the comparator take part. The target is the current counter epoch with those low bits. If that value is below the count at arming, the target is the same low bits in the next 2^32 epoch.
- R5: In 32-bit one-shot mode, when the target lies strictly beyond the next 2^32 boundary of the count at arming, the channel fires first at that boundary. It then fires again at the real target.
- R6: In periodic mode (config bit 0 = 1), a comparator write always loads the hidden period. It changes the visible comparator only when the set-value bit (config bit 2) is 1. Every accepted comparator write clears the set-value bit.
- R7: On a periodic match with a nonzero period, the target advances by the period and the visible comparator shows the new target. In 32-bit mode the visible comparator shows only its low 32 bits, with the upper half zero. With a zero period the match behaves as a one-shot.
- R8: If the count has already passed the advanced target after a periodic match, the period is added once per cycle until the target is strictly ahead of the count. No fire occurs during this catch-up.
- R9: Any configuration write with bit 1 = 1 truncates the comparator and the period to their low 32 bits. In 32-bit mode a write to the upper comparator half (cmp_hsel_i = 1) is ignored entirely.
- R10: Only config bits 2:0 are writable. Bits 4:3 always read 1 and bits 7:5 always read 0.
- R11: While glb_en_i is 1, any accepted configuration or comparator write drops the current arming. The channel re-arms on the next cycle from the new settings and the count at that cycle. A configuration write in the same cycle as a comparator write wins, and the comparator write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_i | input | CW | Shared main counter value |
| glb_en_i | input | 1 | Global enable for the timer block |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 3 | Writable config bits: 0 periodic, 1 32-bit mode, 2 set-value |
| cmp_we_i | input | 1 | Comparator half write strobe |
| cmp_hsel_i | input | 1 | 1 selects the upper comparator half, 0 the lower |
| cmp_wdata_i | input | CW/2 | Comparator half write data |
| fire_o | output | 1 | One-cycle match strobe |
| cmp_rd_o | output | CW | Visible comparator |
| cfg_rd_o | output | CFGW | Configuration word readback |

## Verification
A wrong target shows at the ports in one of two ways. Either fire_o pulses on a count where no fire was expected, or it stays low on the count where a fire was expected. For a periodic channel, the visible comparator also shows the error one cycle after the match.

A stuck catch-up or arm-request flag makes the channel silent on the next matching count. A lost rollover flag is seen at once as a missing fire on the second, real target. Errors in the write path show in the comparator or config readback on the cycle after the write.

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel #(
  parameter int CW   = 64,
  parameter int CFGW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   count_i,
  input  logic            glb_en_i,
  input  logic            cfg_we_i,
  input  logic [2:0]      cfg_wdata_i,
  input  logic            cmp_we_i,
  input  logic            cmp_hsel_i,
  input  logic [CW/2-1:0] cmp_wdata_i,
  output logic            fire_o,
  output logic [CW-1:0]   cmp_rd_o,
  output logic [CFGW-1:0] cfg_rd_o
);
  localparam int HW = CW / 2;
  localparam logic [CW-1:0] EPOCH = {{(HW-1){1'b0}}, 1'b1, {HW{1'b0}}};

  logic [2:0]    cfg_q;
  logic [CW-1:0] cmp_q, per_q, tgt_q, real_q;
  logic          armed_q, wrap_q, chase_q, arm_req_q, en_q;

  wire per_m = cfg_q[0];
  wire w32   = cfg_q[1];
  wire setv  = cfg_q[2];

  wire hit     = glb_en_i && armed_q && !chase_q && (count_i == tgt_q);
  wire hi_blk  = cmp_hsel_i && w32;
  wire cmp_acc = cmp_we_i && !cfg_we_i && !hi_blk;

  assign fire_o   = hit;
  assign cmp_rd_o = cmp_q;
  assign cfg_rd_o = {{(CFGW-5){1'b0}}, 2'b11, cfg_q};

  logic [CW-1:0] lo_ext, lo_fix, nwrap, arm_t, step, step_vis;
  logic          use_wrap;

  always_comb begin
    lo_ext   = {count_i[CW-1:HW], cmp_q[HW-1:0]};
    lo_fix   = (lo_ext < count_i) ? lo_ext + EPOCH : lo_ext;
    nwrap    = {count_i[CW-1:HW] + 1'b1, {HW{1'b0}}};
    arm_t    = w32 ? lo_fix : cmp_q;
    use_wrap = w32 && !per_m && (arm_t > nwrap);
    step     = tgt_q + per_q;
    step_vis = w32 ? {{HW{1'b0}}, step[HW-1:0]} : step;
  end

  function automatic logic [CW-1:0] merge_half(input logic [CW-1:0] old,
                                               input logic mode32,
                                               input logic upper,
                                               input logic [HW-1:0] d);
    if (mode32)     return {{HW{1'b0}}, d};
    else if (upper) return {d, old[HW-1:0]};
    else            return {old[CW-1:HW], d};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      cmp_q     <= '1;
      per_q     <= '0;
      tgt_q     <= '0;
      real_q    <= '0;
      armed_q   <= 1'b0;
      wrap_q    <= 1'b0;
      chase_q   <= 1'b0;
      arm_req_q <= 1'b0;
      en_q      <= 1'b0;
    end else begin
      en_q      <= glb_en_i;
      arm_req_q <= 1'b0;

      if (!glb_en_i) begin
        armed_q <= 1'b0;
        chase_q <= 1'b0;
        wrap_q  <= 1'b0;
      end else if (arm_req_q) begin
        armed_q <= 1'b1;
        chase_q <= 1'b0;
        wrap_q  <= use_wrap;
        tgt_q   <= use_wrap ? nwrap : arm_t;
        real_q  <= arm_t;
      end else if (hit) begin
        if (per_m && per_q != '0) begin
          tgt_q   <= step;
          cmp_q   <= step_vis;
          chase_q <= 1'b1;
        end else if (wrap_q) begin
          wrap_q <= 1'b0;
          tgt_q  <= real_q;
        end else begin
          armed_q <= 1'b0;
        end
      end else if (chase_q) begin
        if (tgt_q <= count_i) begin
          tgt_q <= step;
          cmp_q <= step_vis;
        end else begin
          chase_q <= 1'b0;
        end
      end

      if (glb_en_i && !en_q) arm_req_q <= 1'b1;

      if (cfg_we_i) begin
        cfg_q <= cfg_wdata_i;
        if (cfg_wdata_i[1]) begin
          cmp_q <= {{HW{1'b0}}, cmp_q[HW-1:0]};
          per_q <= {{HW{1'b0}}, per_q[HW-1:0]};
        end
        if (glb_en_i) begin
          arm_req_q <= 1'b1;
          armed_q   <= 1'b0;
          chase_q   <= 1'b0;
        end
      end else if (cmp_acc) begin
        if (!per_m || setv) cmp_q <= merge_half(cmp_q, w32, cmp_hsel_i, cmp_wdata_i);
        if (per_m)          per_q <= merge_half(per_q, w32, cmp_hsel_i, cmp_wdata_i);
        cfg_q[2] <= 1'b0;
        if (glb_en_i) begin
          arm_req_q <= 1'b1;
          armed_q   <= 1'b0;
          chase_q   <= 1'b0;
        end
      end
    end
  end

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o && !wrap_q |=> !fire_o);

  a_r6_setval_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we_i && !cfg_we_i && !(cmp_hsel_i && cfg_rd_o[1]) |=> !cfg_rd_o[2]);

  a_r6_hidden_period: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we_i && !cfg_we_i && cfg_rd_o[0] && !cfg_rd_o[2] && !hit && !chase_q
    |=> $stable(cmp_rd_o));

  a_r9_upper_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we_i && cmp_hsel_i && cfg_rd_o[1] && !cfg_rd_o[0] && !cfg_we_i
    |=> $stable(cmp_rd_o));

  a_r9_truncate: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_i && cfg_wdata_i[1] |=> cmp_rd_o[CW-1:HW] == '0);
endmodule

// File: tb/sim_evt_cmp_channel.sv
`timescale 1ns/1ps
module sim_evt_cmp_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cnt = '0;
  logic        en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_wd = '0;
  logic        cmp_we = 1'b0;
  logic        hsel = 1'b0;
  logic [31:0] cmp_wd = '0;
  logic        fire;
  logic [63:0] cmp_rd;
  logic [7:0]  cfg_rd;
  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  evt_cmp_channel u0 (
    .clk(clk), .rst_n(rst_n), .count_i(cnt), .glb_en_i(en),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .cmp_we_i(cmp_we),
    .cmp_hsel_i(hsel), .cmp_wdata_i(cmp_wd), .fire_o(fire),
    .cmp_rd_o(cmp_rd), .cfg_rd_o(cfg_rd));

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wcfg(input logic [2:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wd = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wcmp(input logic upper, input logic [31:0] d);
    @(negedge clk); cmp_we = 1'b1; hsel = upper; cmp_wd = d;
    @(negedge clk); cmp_we = 1'b0; hsel = 1'b0;
  endtask

  task automatic setc(input logic [63:0] v);
    @(negedge clk); cnt = v; #1;
  endtask

  task automatic t_reset;
    chk("R1 cmp", cmp_rd, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R1 cfg", {56'd0, cfg_rd}, 64'h18);
    chk("R1 fire", {63'd0, fire}, 64'd0);
  endtask

  task automatic t_cfg_mask;
    wcfg(3'b111); #1;
    chk("R10 cfg all", {56'd0, cfg_rd}, 64'h1F);
    wcfg(3'b000); #1;
    chk("R10 cfg clear", {56'd0, cfg_rd}, 64'h18);
  endtask

  task automatic t_oneshot64;
    @(negedge clk); en = 1'b1;
    setc(64'd100);
    wcmp(1'b0, 32'd200);
    wcmp(1'b1, 32'd0);
    chk("R11 cmp", cmp_rd, 64'd200);
    setc(64'd199); chk("R2 early", {63'd0, fire}, 64'd0);
    setc(64'd200); chk("R2 match", {63'd0, fire}, 64'd1);
    setc(64'd201); chk("R2 after", {63'd0, fire}, 64'd0);
    setc(64'd200); chk("R2 no refire", {63'd0, fire}, 64'd0);
  endtask

  task automatic t_disable;
    @(negedge clk); en = 1'b0;
    wcmp(1'b0, 32'd300);
    setc(64'd300); chk("R3 disabled", {63'd0, fire}, 64'd0);
    @(negedge clk); en = 1'b1;
    @(negedge clk);
    @(negedge clk); #1;
    chk("R3 rearm", {63'd0, fire}, 64'd1);
    setc(64'd301);
  endtask

  task automatic t_wide;
    setc(64'h5_0000_1000);
    wcfg(3'b010);
    wcmp(1'b0, 32'h2000);
    chk("R4 cmp", cmp_rd, 64'h2000);
    setc(64'h5_0000_1FFF); chk("R4 early", {63'd0, fire}, 64'd0);
    setc(64'h5_0000_2000); chk("R4 match", {63'd0, fire}, 64'd1);
    setc(64'h5_0000_1000);
    wcmp(1'b0, 32'h800);
    setc(64'h5_0000_0800); chk("R4 same epoch", {63'd0, fire}, 64'd0);
    setc(64'h6_0000_0000); chk("R5 wrap fire", {63'd0, fire}, 64'd1);
    setc(64'h6_0000_0001); chk("R5 quiet", {63'd0, fire}, 64'd0);
    setc(64'h6_0000_0800); chk("R5 real fire", {63'd0, fire}, 64'd1);
    setc(64'h6_0000_0801); chk("R5 done", {63'd0, fire}, 64'd0);
  endtask

  task automatic t_trunc;
    wcmp(1'b1, 32'hABCD); #1;
    chk("R9 upper ignored", cmp_rd, 64'h800);
    wcfg(3'b000);
    wcmp(1'b1, 32'h12);
    wcmp(1'b0, 32'h34);
    chk("R9 wide value", cmp_rd, 64'h12_0000_0034);
    wcfg(3'b010); #1;
    chk("R9 truncated", cmp_rd, 64'h34);
  endtask

  task automatic t_periodic;
    setc(64'd1000);
    wcfg(3'b101);
    wcmp(1'b0, 32'd1100); #1;
    chk("R6 setval cmp", cmp_rd, 64'd1100);
    chk("R6 setval cleared", {63'd0, cfg_rd[2]}, 64'd0);
    wcmp(1'b1, 32'd0);
    wcmp(1'b0, 32'd50); #1;
    chk("R6 hidden period", cmp_rd, 64'd1100);
    setc(64'd1099); chk("R7 early", {63'd0, fire}, 64'd0);
    setc(64'd1100); chk("R7 match", {63'd0, fire}, 64'd1);
    setc(64'd1101);
    chk("R7 advanced", cmp_rd, 64'd1150);
    chk("R7 quiet", {63'd0, fire}, 64'd0);
    setc(64'd1150); chk("R7 second", {63'd0, fire}, 64'd1);
    setc(64'd1151);
    setc(64'd1200); chk("R7 third", {63'd0, fire}, 64'd1);
    setc(64'd1390); chk("R8 no fire", {63'd0, fire}, 64'd0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #1;
      chk("R8 catchup quiet", {63'd0, fire}, 64'd0);
    end
    chk("R8 caught up", cmp_rd, 64'd1400);
    setc(64'd1400); chk("R8 next fire", {63'd0, fire}, 64'd1);
  endtask

  task automatic t_p32;
    setc(64'h2_FFFF_FFF0);
    wcfg(3'b111);
    wcmp(1'b0, 32'hFFFF_FFF8);
    setc(64'h2_FFFF_FFF8); chk("R7 w32 match", {63'd0, fire}, 64'd1);
    setc(64'h2_FFFF_FFF9);
    chk("R7 w32 visible", cmp_rd, 64'hFFFF_FFF0);
  endtask

  initial begin
    #(200000 * 5);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset;
    t_cfg_mask;
    t_oneshot64;
    t_disable;
    t_wide;
    t_trunc;
    t_periodic;
    t_p32;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule